// File: doc/BRIEF.md
# Host Shared-RAM Access Port

This block gives a host processor byte-wide register access to the memory that it shares with a coprocessor. The host loads a 16-bit pointer one byte at a time, as a high half and a low half. It then reads or writes the memory byte at that pointer through a data register. If the host enables auto-increment, every data access moves the pointer forward by one, so a block of bytes can be streamed through one register. The shared memory sits inside the block as a dual-port array. The coprocessor side has a plain address, data and write-enable port.

A single control byte serves the host and the coprocessor. Through it the host holds the coprocessor in reset or lets it run, and rings a doorbell interrupt toward it. The coprocessor raises two flags that drive the host interrupt line. The host clears a flag by writing a 1 to it. Only the even register offsets are decoded: address bit 0 is ignored, so each odd offset is a copy of the even offset below it.

Top module: `shram_host_port`

## Requirements
- R1: After reset the pointer is 0x0000, the control byte reads 0x00, and `cp_run`, `cp_irq` and `host_irq` are all low.
- R2: Word offset 0 (host_addr 0 or 1) reads and writes the pointer high byte. Word offset 1 (host_addr 2 or 3) reads and writes the pointer low byte. host_addr bit 0 is ignored.
- R3: Word offset 4 (host_addr 8 or 9) is the data port. A read returns the memory byte at the low MEM_AW pointer bits in the same cycle. A write stores host_wdata there at the clock edge.
- R4: Control bit 1 is auto-increment. While it is 1, each data-port access, read or write, adds one to the pointer at that edge. While it is 0, a data-port access leaves the pointer unchanged.
- R5: The pointer wraps from 0xFFFF to 0x0000 on an auto-increment.
- R6: Control bit 2 is the run bit and drives `cp_run`. Writing 0 holds the coprocessor in reset and writing 1 releases it, from the cycle after the write.
- R7: Control bit 3 is the doorbell and drives `cp_irq`. The host sets it by writing 1 to it; writing 0 leaves it unchanged. A pulse on `cp_irq_ack` clears it, and a host set in the same cycle as the pulse wins.
- R8: Control bits 4 and 5 are flags set by `cp_flag_set[0]` and `cp_flag_set[1]`. `host_irq` is high while either flag is set. A host write of 1 to a flag clears it, and a write of 0 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R9: Control bits 6 and 7 always read 0. Bit 0 stores what the host writes. Word offsets 3, 5, 6 and 7 read 0x00, and writes to them have no effect.
- R10: The coprocessor port reads `mem[cp_addr]` in the same cycle and writes it on `cp_wr`. When both ports write one address in the same cycle, the host byte is kept (HOST_WINS=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Host byte offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the access cycle |
| host_irq | output | 1 | Interrupt to the host |
| cp_wr | input | 1 | Coprocessor memory write enable |
| cp_addr | input | MEM_AW | Coprocessor memory address |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_rdata | output | 8 | Coprocessor read data |
| cp_run | output | 1 | 1 = coprocessor released from reset |
| cp_irq | output | 1 | Doorbell interrupt to the coprocessor |
| cp_irq_ack | input | 1 | Coprocessor acknowledges the doorbell |
| cp_flag_set | input | 2 | Coprocessor sets host interrupt flags |

## Verification
The assertions check on every cycle the effects that follow one edge after their cause:
- the pointer steps by one, or holds, on each data access, depending on auto-increment;
- the run output follows the control write;
- the doorbell rises on a host set and falls on an acknowledge;
- any coprocessor flag set raises the host interrupt;
- control bits 6 and 7 read as zero.

Only the bench scenarios show the following:
- that memory contents land at the pointed-to byte;
- that the odd offsets alias the even ones;
- that the pointer wraps;
- that unmapped offsets ignore writes;
- that a write of 0 leaves the flags and doorbell alone;
- which port wins a write to the same address.

// File: rtl/shram_pkg.sv
package shram_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 3;
   localparam logic [WORD_W-1:0] WO_PTR_HI = 3'd0;
   localparam logic [WORD_W-1:0] WO_PTR_LO = 3'd1;
   localparam logic [WORD_W-1:0] WO_CTRL   = 3'd2;
   localparam logic [WORD_W-1:0] WO_DATA   = 3'd4;
   localparam int CB_BYPASS  = 0;
   localparam int CB_AUTOINC = 1;
   localparam int CB_RUN     = 2;
   localparam int CB_BELL    = 3;
   localparam int CB_FLAG0   = 4;
   localparam int NUM_FLAGS  = 2;

   typedef struct packed {
      logic ptr_hi;
      logic ptr_lo;
      logic ctrl;
      logic data;
   } reg_hit_t;

   function automatic reg_hit_t decode_word(input logic [WORD_W-1:0] w, input logic sel);
      reg_hit_t h;
      h.ptr_hi = sel && (w == WO_PTR_HI);
      h.ptr_lo = sel && (w == WO_PTR_LO);
      h.ctrl   = sel && (w == WO_CTRL);
      h.data   = sel && (w == WO_DATA);
      return h;
   endfunction
endpackage

// File: rtl/shram_ptr.sv
module shram_ptr
   import shram_pkg::*;
#(
   parameter int PTR_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_hi,
   input  logic                 wr_lo,
   input  logic                 step,
   input  logic [BYTE_W-1:0]    wdata,
   output logic [PTR_W-1:0]     ptr_q
);
   localparam int HI_W = PTR_W - BYTE_W;

   if (PTR_W <= BYTE_W || PTR_W > 2 * BYTE_W) begin : g_bad_width
      $error("shram_ptr: PTR_W must lie in 9..16");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (wr_hi) begin
         ptr_q[PTR_W-1:BYTE_W] <= wdata[HI_W-1:0];
      end else if (wr_lo) begin
         ptr_q[BYTE_W-1:0] <= wdata;
      end else if (step) begin
         ptr_q <= ptr_q + PTR_W'(1);
      end
   end
endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
   import shram_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_ctrl,
   input  logic [BYTE_W-1:0]    wdata,
   input  logic                 irq_ack,
   input  logic [NUM_FLAGS-1:0] flag_set,
   output logic [BYTE_W-1:0]    ctrl_q
);
   logic                 bypass_q, autoinc_q, run_q, bell_q;
   logic [NUM_FLAGS-1:0] flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bypass_q  <= 1'b0;
         autoinc_q <= 1'b0;
         run_q     <= 1'b0;
      end else if (wr_ctrl) begin
         bypass_q  <= wdata[CB_BYPASS];
         autoinc_q <= wdata[CB_AUTOINC];
         run_q     <= wdata[CB_RUN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bell_q <= 1'b0;
      end else if (wr_ctrl && wdata[CB_BELL]) begin
         bell_q <= 1'b1;
      end else if (irq_ack) begin
         bell_q <= 1'b0;
      end
   end

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[i] <= 1'b0;
         end else if (flag_set[i]) begin
            flag_q[i] <= 1'b1;
         end else if (wr_ctrl && wdata[CB_FLAG0+i]) begin
            flag_q[i] <= 1'b0;
         end
      end
   end

   always_comb begin
      ctrl_q                              = '0;
      ctrl_q[CB_BYPASS]                   = bypass_q;
      ctrl_q[CB_AUTOINC]                  = autoinc_q;
      ctrl_q[CB_RUN]                      = run_q;
      ctrl_q[CB_BELL]                     = bell_q;
      ctrl_q[CB_FLAG0+NUM_FLAGS-1:CB_FLAG0] = flag_q;
   end
endmodule

// File: rtl/shram_mem.sv
module shram_mem
   import shram_pkg::*;
#(
   parameter int MEM_AW    = 8,
   parameter bit HOST_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              h_we,
   input  logic [MEM_AW-1:0] h_addr,
   input  logic [BYTE_W-1:0] h_wdata,
   output logic [BYTE_W-1:0] h_rdata,
   input  logic              c_we,
   input  logic [MEM_AW-1:0] c_addr,
   input  logic [BYTE_W-1:0] c_wdata,
   output logic [BYTE_W-1:0] c_rdata
);
   localparam int DEPTH = 1 << MEM_AW;

   if (MEM_AW < 1 || MEM_AW > 12) begin : g_bad_depth
      $error("shram_mem: MEM_AW must lie in 1..12");
   end

   logic [BYTE_W-1:0] mem_q [DEPTH];

   if (HOST_WINS) begin : g_host_last
      always_ff @(posedge clk) begin
         if (c_we) mem_q[c_addr] <= c_wdata;
         if (h_we) mem_q[h_addr] <= h_wdata;
      end
   end else begin : g_cp_last
      always_ff @(posedge clk) begin
         if (h_we) mem_q[h_addr] <= h_wdata;
         if (c_we) mem_q[c_addr] <= c_wdata;
      end
   end

   assign h_rdata = mem_q[h_addr];
   assign c_rdata = mem_q[c_addr];
endmodule

// File: rtl/shram_host_port.sv
module shram_host_port
   import shram_pkg::*;
#(
   parameter int PTR_W     = 16,
   parameter int MEM_AW    = 8,
   parameter bit HOST_WINS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_sel,
   input  logic                 host_wr,
   input  logic [3:0]           host_addr,
   input  logic [7:0]           host_wdata,
   output logic [7:0]           host_rdata,
   output logic                 host_irq,
   input  logic                 cp_wr,
   input  logic [MEM_AW-1:0]    cp_addr,
   input  logic [7:0]           cp_wdata,
   output logic [7:0]           cp_rdata,
   output logic                 cp_run,
   output logic                 cp_irq,
   input  logic                 cp_irq_ack,
   input  logic [1:0]           cp_flag_set
);
   if (MEM_AW > PTR_W) begin : g_bad_map
      $error("shram_host_port: MEM_AW exceeds PTR_W");
   end

   reg_hit_t          rd_hit, wr_hit;
   logic [PTR_W-1:0]  ptr_q;
   logic [7:0]        ctrl_q;
   logic [7:0]        mem_rd;
   logic              autoinc;

   assign rd_hit  = decode_word(host_addr[3:1], host_sel);
   assign wr_hit  = decode_word(host_addr[3:1], host_sel && host_wr);
   assign autoinc = ctrl_q[CB_AUTOINC];

   shram_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_hi (wr_hit.ptr_hi),
      .wr_lo (wr_hit.ptr_lo),
      .step  (rd_hit.data && autoinc),
      .wdata (host_wdata),
      .ptr_q (ptr_q)
   );

   shram_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_hit.ctrl),
      .wdata    (host_wdata),
      .irq_ack  (cp_irq_ack),
      .flag_set (cp_flag_set),
      .ctrl_q   (ctrl_q)
   );

   shram_mem #(.MEM_AW(MEM_AW), .HOST_WINS(HOST_WINS)) u_mem (
      .clk     (clk),
      .h_we    (wr_hit.data),
      .h_addr  (ptr_q[MEM_AW-1:0]),
      .h_wdata (host_wdata),
      .h_rdata (mem_rd),
      .c_we    (cp_wr),
      .c_addr  (cp_addr),
      .c_wdata (cp_wdata),
      .c_rdata (cp_rdata)
   );

   always_comb begin
      host_rdata = '0;
      if (rd_hit.ptr_hi)      host_rdata = 8'(ptr_q[PTR_W-1:BYTE_W]);
      else if (rd_hit.ptr_lo) host_rdata = ptr_q[BYTE_W-1:0];
      else if (rd_hit.ctrl)   host_rdata = ctrl_q;
      else if (rd_hit.data)   host_rdata = mem_rd;
   end

   assign cp_run   = ctrl_q[CB_RUN];
   assign cp_irq   = ctrl_q[CB_BELL];
   assign host_irq = |ctrl_q[CB_FLAG0+NUM_FLAGS-1:CB_FLAG0];
endmodule

// File: rtl/shram_host_port_chk.sv
module shram_host_port_chk #(
   parameter int PTR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_sel,
   input logic             host_wr,
   input logic [3:0]       host_addr,
   input logic [7:0]       host_wdata,
   input logic [7:0]       host_rdata,
   input logic             host_irq,
   input logic             cp_run,
   input logic             cp_irq,
   input logic             cp_irq_ack,
   input logic [1:0]       cp_flag_set,
   input logic [PTR_W-1:0] ptr,
   input logic             autoinc
);
   logic ctl_wr, ctl_rd, dat_acc;
   assign ctl_wr  = host_sel && host_wr && (host_addr[3:1] == 3'd2);
   assign ctl_rd  = host_sel && !host_wr && (host_addr[3:1] == 3'd2);
   assign dat_acc = host_sel && (host_addr[3:1] == 3'd4);

   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dat_acc && autoinc |=> ptr == PTR_W'($past(ptr) + PTR_W'(1)));
   assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dat_acc && !autoinc |=> $stable(ptr));
   assert_run_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && host_wdata[2] |=> cp_run);
   assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && !host_wdata[2] |=> !cp_run);
   assert_bell_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && host_wdata[3] |=> cp_irq);
   assert_bell_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cp_irq_ack && !(ctl_wr && host_wdata[3]) |=> !cp_irq);
   assert_flag_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|cp_flag_set) |=> host_irq);
   assert_top_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd |-> host_rdata[7:6] == 2'b00);
endmodule

bind shram_host_port shram_host_port_chk #(.PTR_W(PTR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_sel    (host_sel),
   .host_wr     (host_wr),
   .host_addr   (host_addr),
   .host_wdata  (host_wdata),
   .host_rdata  (host_rdata),
   .host_irq    (host_irq),
   .cp_run      (cp_run),
   .cp_irq      (cp_irq),
   .cp_irq_ack  (cp_irq_ack),
   .cp_flag_set (cp_flag_set),
   .ptr         (ptr_q),
   .autoinc     (autoinc)
);

// File: tb/shram_host_port_test.sv
module shram_host_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel = 1'b0, host_wr = 1'b0;
   logic [3:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       host_irq;
   logic       cp_wr = 1'b0;
   logic [7:0] cp_addr = '0, cp_wdata = '0;
   logic [7:0] cp_rdata;
   logic       cp_run, cp_irq;
   logic       cp_irq_ack = 1'b0;
   logic [1:0] cp_flag_set = '0;

   int n_chk = 0, n_bad = 0;
   logic [7:0] rd;

   always #10 clk = ~clk;

   shram_host_port uut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_irq(host_irq), .cp_wr(cp_wr), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
      .cp_rdata(cp_rdata), .cp_run(cp_run), .cp_irq(cp_irq),
      .cp_irq_ack(cp_irq_ack), .cp_flag_set(cp_flag_set));

   // {check, write, addr, wdata, expected}
   localparam int NV = 26;
   localparam logic [21:0] VEC [NV] = '{
      {1'b0, 1'b1, 4'h0, 8'h12, 8'h00},   // R2 ptr hi
      {1'b1, 1'b0, 4'h0, 8'h00, 8'h12},
      {1'b0, 1'b1, 4'h3, 8'h34, 8'h00},   // R2 odd alias of lo
      {1'b1, 1'b0, 4'h2, 8'h00, 8'h34},
      {1'b1, 1'b0, 4'h1, 8'h00, 8'h12},
      {1'b0, 1'b1, 4'h4, 8'h02, 8'h00},   // R4 autoinc on
      {1'b1, 1'b0, 4'h4, 8'h00, 8'h02},
      {1'b0, 1'b1, 4'h8, 8'hA1, 8'h00},   // R3 write 0x34
      {1'b0, 1'b1, 4'h9, 8'hA2, 8'h00},   // R3 write 0x35 via alias
      {1'b1, 1'b0, 4'h2, 8'h00, 8'h36},   // R4 stepped twice
      {1'b0, 1'b1, 4'h2, 8'h34, 8'h00},
      {1'b1, 1'b0, 4'h8, 8'h00, 8'hA1},
      {1'b1, 1'b0, 4'h8, 8'h00, 8'hA2},
      {1'b1, 1'b0, 4'h2, 8'h00, 8'h36},   // R4 read steps too
      {1'b0, 1'b1, 4'h4, 8'h00, 8'h00},   // autoinc off
      {1'b0, 1'b1, 4'h2, 8'h34, 8'h00},
      {1'b1, 1'b0, 4'h8, 8'h00, 8'hA1},
      {1'b1, 1'b0, 4'h8, 8'h00, 8'hA1},
      {1'b1, 1'b0, 4'h2, 8'h00, 8'h34},   // R4 no step
      {1'b0, 1'b1, 4'hC, 8'h5A, 8'h00},   // R9 unmapped write
      {1'b1, 1'b0, 4'hC, 8'h00, 8'h00},
      {1'b1, 1'b0, 4'h4, 8'h00, 8'h00},
      {1'b1, 1'b0, 4'h0, 8'h00, 8'h12},
      {1'b0, 1'b1, 4'h5, 8'hC1, 8'h00},   // R9 bit0 kept, 7:6 dropped
      {1'b1, 1'b0, 4'h4, 8'h00, 8'h01},
      {1'b0, 1'b1, 4'h4, 8'h00, 8'h00}
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // Called at a negedge; holds the access over one posedge.
   task automatic access(input logic w, input logic [3:0] a, input logic [7:0] d);
      host_sel = 1'b1; host_wr = w; host_addr = a; host_wdata = d;
      #5 rd = host_rdata;
      @(negedge clk);
      host_sel = 1'b0; host_wr = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   initial begin
      #(20 * 20000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 cp_run", {7'd0, cp_run}, 8'h00);
      check("R1 cp_irq", {7'd0, cp_irq}, 8'h00);
      check("R1 host_irq", {7'd0, host_irq}, 8'h00);
      access(1'b0, 4'h4, 8'h00); check("R1 ctrl", rd, 8'h00);
      access(1'b0, 4'h0, 8'h00); check("R1 ptr hi", rd, 8'h00);
      access(1'b0, 4'h2, 8'h00); check("R1 ptr lo", rd, 8'h00);

      for (int i = 0; i < NV; i++) begin
         access(VEC[i][20], VEC[i][19:16], VEC[i][15:8]);
         if (VEC[i][21]) check($sformatf("R2/R3/R4/R9 vec %0d", i), rd, VEC[i][7:0]);
      end

      // R5 wrap
      access(1'b1, 4'h0, 8'hFF);
      access(1'b1, 4'h2, 8'hFF);
      access(1'b1, 4'h4, 8'h02);
      access(1'b1, 4'h8, 8'h5A);
      access(1'b0, 4'h0, 8'h00); check("R5 wrap hi", rd, 8'h00);
      access(1'b0, 4'h2, 8'h00); check("R5 wrap lo", rd, 8'h00);
      cp_addr = 8'hFF; #1;
      check("R10 cp read of host byte", cp_rdata, 8'h5A);

      // R6 run
      access(1'b1, 4'h4, 8'h04);
      check("R6 released", {7'd0, cp_run}, 8'h01);
      access(1'b1, 4'h4, 8'h00);
      check("R6 held", {7'd0, cp_run}, 8'h00);

      // R7 doorbell
      access(1'b1, 4'h4, 8'h0C);
      check("R7 ring", {7'd0, cp_irq}, 8'h01);
      access(1'b1, 4'h4, 8'h04);
      check("R7 write 0 no effect", {7'd0, cp_irq}, 8'h01);
      cp_irq_ack = 1'b1; idle(); cp_irq_ack = 1'b0;
      check("R7 ack clears", {7'd0, cp_irq}, 8'h00);
      cp_irq_ack = 1'b1; access(1'b1, 4'h4, 8'h0C); cp_irq_ack = 1'b0;
      check("R7 set beats ack", {7'd0, cp_irq}, 8'h01);
      cp_irq_ack = 1'b1; idle(); cp_irq_ack = 1'b0;

      // R8 flags
      cp_flag_set = 2'b01; idle(); cp_flag_set = 2'b00;
      check("R8 flag0 irq", {7'd0, host_irq}, 8'h01);
      access(1'b0, 4'h4, 8'h00); check("R8 ctrl read", rd, 8'h14);
      access(1'b1, 4'h4, 8'h04);
      check("R8 write 0 keeps", {7'd0, host_irq}, 8'h01);
      access(1'b1, 4'h4, 8'h14);
      check("R8 clear", {7'd0, host_irq}, 8'h00);
      cp_flag_set = 2'b10; access(1'b1, 4'h4, 8'h24); cp_flag_set = 2'b00;
      check("R8 set beats clear", {7'd0, host_irq}, 8'h01);
      access(1'b0, 4'h4, 8'h00); check("R8 flag1 bit", rd, 8'h24);
      access(1'b1, 4'h4, 8'h24);
      check("R8 flag1 cleared", {7'd0, host_irq}, 8'h00);

      // R10 coprocessor port
      cp_addr = 8'h10; cp_wdata = 8'h77; cp_wr = 1'b1; idle(); cp_wr = 1'b0;
      access(1'b1, 4'h0, 8'h00);
      access(1'b1, 4'h2, 8'h10);
      access(1'b0, 4'h8, 8'h00); check("R10 cp write seen by host", rd, 8'h77);
      cp_wdata = 8'h22; cp_wr = 1'b1; access(1'b1, 4'h8, 8'h11); cp_wr = 1'b0;
      access(1'b0, 4'h8, 8'h00); check("R10 host wins collision", rd, 8'h11);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule